// File: doc/BRIEF.md
# Sector Erase Queue Timer

This block gathers sector-erase requests inside an embedded flash controller and decides when the queued erase may begin. An upstream command decoder presents one event per accepted sector-erase command. Each event carries the 3-bit sector index, which the decoder takes from address bits 16..14, so the eight 16 KiB sectors start at 0x00000, 0x04000 and so on up to 0x1C000. The decoder also reports any other completed command, and a separate event marks each falling edge of the write strobe.

The first sector command opens an acceptance window whose length is set in clock cycles from the clock frequency and the window time (80 µs by default). Further sector commands inside the window add their sectors to the selection and restart the window. A write-strobe falling edge inside the window also restarts it. Any other command inside the window drops the whole queue and signals an abort, so the controller returns to read mode.

When the window runs out, the block issues a one-cycle start pulse together with the final sector mask. It then holds that mask until the array logic reports that the erase is complete. A status output reports whether the window is open, and software reads this status on data bit D3.

Top module: `seq_erase_queue`

## Requirements
- R1: After reset, sel_mask is 0 and win_open, erase_start and abort are all low.
- R2: A sector command while nothing is queued sets bit i of sel_mask, where i is the 3-bit sector index. win_open rises on the cycle after the command is sampled.
- R3: With no further events, win_open stays high for exactly WIN_CYC cycles after the accepting edge. erase_start pulses on the edge WIN_CYC cycles after the accepting edge, and win_open is low from that edge on.
- R4: Each sector command inside the window ORs its sector bit into sel_mask and restarts the window. Sectors may arrive in any order, repeat, and reach all eight.
- R5: A write-strobe falling edge inside the window restarts the window and leaves sel_mask unchanged. This includes a falling edge sampled on the edge where the window would have expired.
- R6: Any other command inside the window produces a one-cycle abort pulse and clears sel_mask. win_open drops and no erase_start follows. The abort takes priority over a sector command in the same cycle.
- R7: erase_start is a single-cycle pulse. sel_mask holds the complete final selection during that pulse and stays unchanged until erase_done.
- R8: While an erase is running, sector commands, other commands and write-strobe edges are ignored. sel_mask stays unchanged, win_open stays low, and no abort or start appears.
- R9: erase_done during a running erase clears sel_mask and returns the block to idle, where a new sector command is accepted again.
- R10: Other commands and write-strobe edges while idle have no effect: no abort, win_open stays low and sel_mask stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_cmd_vld | input | 1 | One-cycle event: a sector-erase command was decoded |
| sect_addr | input | SECT_W (3) | Sector index carried by the sector command (address bits 16..14) |
| other_cmd_vld | input | 1 | One-cycle event: any other command was decoded |
| we_fall | input | 1 | One-cycle event: write strobe fell |
| erase_done | input | 1 | Array logic reports the running erase finished |
| sel_mask | output | NUM_SECT (8) | Sectors queued for erase, bit i = sector i |
| erase_start | output | 1 | One-cycle pulse: window expired, erase begins |
| win_open | output | 1 | Acceptance window open (status bit D3) |
| abort | output | 1 | One-cycle pulse: queued erase dropped |

## Verification
The bench targets the window edges. It checks that the start arrives on exactly the cycle the window expires: a design off by one would pulse early or late, and the scoreboard's cycle stamp catches either. It also sends a write-strobe edge on the very edge of expiry, which a design that lets expiry win would turn into a premature start. Abort ordering is exercised with a sector command and a foreign command in the same cycle, where a wrong priority leaves a nonzero mask. Commands sent during a running erase and while idle expose a design that still accepts sectors or raises stray aborts.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_OPEN  = 2'd1,
        Q_ERASE = 2'd2
    } q_state_e;

endpackage

// File: rtl/seq_sector_dec.sv
module seq_sector_dec #(
    parameter int NUM_SECT = 8,
    parameter int SECT_W   = $clog2(NUM_SECT)
) (
    input  logic [SECT_W-1:0]   sect_idx,
    output logic [NUM_SECT-1:0] onehot
);

    // One compare per sector; the index range covers exactly NUM_SECT bits.
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        assign onehot[g] = (sect_idx == SECT_W'(g));
    end

endmodule

// File: rtl/seq_win_timer.sv
module seq_win_timer #(
    parameter int WIN_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int              CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD  = CNT_W'(WIN_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = LOAD;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R5: a restart always brings the full window back.
    p_reload_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == LOAD));

    // R3: the window shrinks by exactly one per running cycle.
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/seq_erase_queue.sv
module seq_erase_queue
    import seq_pkg::*;
#(
    parameter int NUM_SECT = 8,
    parameter int SECT_W   = $clog2(NUM_SECT),
    parameter int CLK_MHZ  = 125,
    parameter int WIN_US   = 80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_cmd_vld,
    input  logic [SECT_W-1:0]   sect_addr,
    input  logic                other_cmd_vld,
    input  logic                we_fall,
    input  logic                erase_done,
    output logic [NUM_SECT-1:0] sel_mask,
    output logic                erase_start,
    output logic                win_open,
    output logic                abort
);

    localparam int WIN_CYC = CLK_MHZ * WIN_US;

    typedef struct packed {
        q_state_e            st;
        logic [NUM_SECT-1:0] mask;
        logic                start;
        logic                abort;
    } ctl_t;

    ctl_t                ctl_d, ctl_q;
    logic [NUM_SECT-1:0] sect_bit;
    logic                t_load;
    logic                t_expired;

    seq_sector_dec #(
        .NUM_SECT (NUM_SECT),
        .SECT_W   (SECT_W)
    ) i_dec (
        .sect_idx (sect_addr),
        .onehot   (sect_bit)
    );

    seq_win_timer #(
        .WIN_CYC (WIN_CYC)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .run     (ctl_q.st == Q_OPEN),
        .expired (t_expired)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        ctl_d.abort = 1'b0;
        t_load      = 1'b0;
        unique case (ctl_q.st)
            Q_IDLE: begin
                if (sec_cmd_vld) begin
                    ctl_d.mask = sect_bit;
                    ctl_d.st   = Q_OPEN;
                    t_load     = 1'b1;
                end
            end
            Q_OPEN: begin
                if (other_cmd_vld) begin
                    // foreign command wins over everything in the window
                    ctl_d.mask  = '0;
                    ctl_d.abort = 1'b1;
                    ctl_d.st    = Q_IDLE;
                end else if (sec_cmd_vld || we_fall) begin
                    // restart keeps the window open even on its last cycle
                    if (sec_cmd_vld) begin
                        ctl_d.mask = ctl_q.mask | sect_bit;
                    end
                    t_load = 1'b1;
                end else if (t_expired) begin
                    ctl_d.start = 1'b1;
                    ctl_d.st    = Q_ERASE;
                end
            end
            Q_ERASE: begin
                if (erase_done) begin
                    ctl_d.mask = '0;
                    ctl_d.st   = Q_IDLE;
                end
            end
            default: begin
                ctl_d.mask = '0;
                ctl_d.st   = Q_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: Q_IDLE, mask: '0, start: 1'b0, abort: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sel_mask    = ctl_q.mask;
    assign erase_start = ctl_q.start;
    assign win_open    = (ctl_q.st == Q_OPEN);
    assign abort       = ctl_q.abort;

    // R2: an open window always has at least one sector queued.
    p_open_has_sector_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> (sel_mask != '0));

    // R3: start and open status never overlap.
    p_start_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_open && erase_start));

    // R7: the start pulse lasts one cycle and carries a selection.
    p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);
    p_start_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> (sel_mask != '0));

    // R6: abort leaves nothing queued and the window closed.
    p_abort_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (sel_mask == '0 && !win_open));

    // R10: abort only follows an open window.
    p_abort_from_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $past(win_open));

    // R8: a running erase keeps its selection until done.
    p_erase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && sel_mask != '0 && !erase_done) |=> $stable(sel_mask));

endmodule

// File: tb/test_seq_erase_queue.sv
module test_seq_erase_queue;

    localparam int W = 8;  // CLK_MHZ=2, WIN_US=4

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_cmd_vld = 1'b0;
    logic [2:0] sect_addr = '0;
    logic       other_cmd_vld = 1'b0;
    logic       we_fall = 1'b0;
    logic       erase_done = 1'b0;
    logic [7:0] sel_mask;
    logic       erase_start;
    logic       win_open;
    logic       abort;

    seq_erase_queue #(
        .NUM_SECT (8),
        .SECT_W   (3),
        .CLK_MHZ  (2),
        .WIN_US   (4)
    ) i_seq_erase_queue (
        .clk           (clk),
        .rst_n         (rst_n),
        .sec_cmd_vld   (sec_cmd_vld),
        .sect_addr     (sect_addr),
        .other_cmd_vld (other_cmd_vld),
        .we_fall       (we_fall),
        .erase_done    (erase_done),
        .sel_mask      (sel_mask),
        .erase_start   (erase_start),
        .win_open      (win_open),
        .abort         (abort)
    );

    always #4 clk = ~clk;  // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        int         at;
        bit         is_abort;
        logic [7:0] mask;
    } ev_t;
    ev_t exp_q[$];

    function automatic void check(string req, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
        end
    endfunction

    function automatic void push_ev(int at, bit ab, logic [7:0] m);
        ev_t e;
        e.at = at;
        e.is_abort = ab;
        e.mask = m;
        exp_q.push_back(e);
    endfunction

    // Monitor: pops expected start/abort events and compares them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                ev_t m;
                m = exp_q.pop_front();
                check(m.is_abort ? "R6" : "R3", "missing event at cycle", 32'(cyc), 32'(m.at));
            end
            if (erase_start || abort) begin
                if (exp_q.size() == 0) begin
                    check("R8/R10", "unexpected start/abort", {30'd0, erase_start, abort}, 32'd0);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    check("R3", "event cycle", 32'(cyc), 32'(e.at));
                    check(e.is_abort ? "R6" : "R7", "event kind (abort)", 32'(abort), 32'(e.is_abort));
                    check(e.is_abort ? "R6" : "R7", "mask at event", 32'(sel_mask), 32'(e.mask));
                end
            end
        end
    end

    task automatic pulse(input bit s, input logic [2:0] a, input bit o, input bit w, input bit d,
                         output int e_n);
        @(negedge clk);
        sec_cmd_vld   = s;
        sect_addr     = a;
        other_cmd_vld = o;
        we_fall       = w;
        erase_done    = d;
        e_n           = cyc + 1;
        @(negedge clk);
        sec_cmd_vld   = 1'b0;
        other_cmd_vld = 1'b0;
        we_fall       = 1'b0;
        erase_done    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    bit done_flag = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int a, b, c, t;
        repeat (3) @(negedge clk);
        check("R1", "mask in reset", 32'(sel_mask), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "mask", 32'(sel_mask), 32'd0);
        check("R1", "win_open", 32'(win_open), 32'd0);
        check("R1", "start/abort", {30'd0, erase_start, abort}, 32'd0);

        // Single sector, full window (R2, R3)
        pulse(1, 3'd3, 0, 0, 0, a);
        check("R2", "win_open after accept", 32'(win_open), 32'd1);
        check("R2", "mask sector 3", 32'(sel_mask), 32'h08);
        push_ev(a + W, 0, 8'h08);
        idle(W - 1);
        check("R3", "win_open last cycle", 32'(win_open), 32'd1);
        idle(1);
        check("R3", "erase_start at expiry", 32'(erase_start), 32'd1);
        check("R3", "win_open after expiry", 32'(win_open), 32'd0);

        // Ignored during erase (R8)
        pulse(1, 3'd5, 0, 0, 0, t);
        check("R8", "late sector not added", 32'(sel_mask), 32'h08);
        pulse(0, 3'd0, 1, 0, 0, t);
        check("R8", "mask after other cmd", 32'(sel_mask), 32'h08);
        pulse(0, 3'd0, 0, 1, 0, t);
        idle(W + 2);
        check("R8", "mask held", 32'(sel_mask), 32'h08);
        check("R8", "win_open low", 32'(win_open), 32'd0);

        // Completion (R9)
        pulse(0, 3'd0, 0, 0, 1, t);
        check("R9", "mask cleared on done", 32'(sel_mask), 32'd0);
        check("R9", "idle after done", 32'(win_open), 32'd0);

        // Multiple sectors with restarts (R4, R9 re-accept)
        pulse(1, 3'd0, 0, 0, 0, a);
        check("R9", "accepted after done", 32'(win_open), 32'd1);
        idle(5);
        pulse(1, 3'd7, 0, 0, 0, b);
        check("R4", "mask two sectors", 32'(sel_mask), 32'h81);
        idle(5);
        pulse(1, 3'd0, 0, 0, 0, c);
        check("R4", "repeat sector", 32'(sel_mask), 32'h81);
        check("R4", "window extended", 32'(win_open), 32'd1);
        push_ev(c + W, 0, 8'h81);
        idle(W);
        pulse(0, 3'd0, 0, 0, 1, t);

        // Strobe restart, including on the expiry edge (R5)
        pulse(1, 3'd2, 0, 0, 0, a);
        idle(6);
        pulse(0, 3'd0, 0, 1, 0, b);
        check("R5", "expiry-edge restart edge", 32'(b), 32'(a + W));
        check("R5", "win_open after restart", 32'(win_open), 32'd1);
        check("R5", "mask unchanged", 32'(sel_mask), 32'h04);
        idle(2);
        pulse(0, 3'd0, 0, 1, 0, c);
        push_ev(c + W, 0, 8'h04);
        idle(W);
        pulse(0, 3'd0, 0, 0, 1, t);

        // Abort (R6)
        pulse(1, 3'd1, 0, 0, 0, a);
        pulse(1, 3'd6, 0, 0, 0, b);
        check("R4", "mask 1 and 6", 32'(sel_mask), 32'h42);
        push_ev(cyc + 2, 1, 8'h00);
        pulse(0, 3'd0, 1, 0, 0, t);
        check("R6", "mask cleared", 32'(sel_mask), 32'd0);
        check("R6", "window closed", 32'(win_open), 32'd0);
        idle(W + 3);

        // Abort priority over same-cycle sector command (R6)
        pulse(1, 3'd4, 0, 0, 0, a);
        push_ev(cyc + 2, 1, 8'h00);
        pulse(1, 3'd5, 1, 0, 0, t);
        check("R6", "priority mask", 32'(sel_mask), 32'd0);
        check("R6", "priority window", 32'(win_open), 32'd0);
        idle(W + 3);

        // Idle ignores foreign events (R10)
        pulse(0, 3'd0, 1, 0, 0, t);
        pulse(0, 3'd0, 0, 1, 0, t);
        idle(W + 2);
        check("R10", "win_open idle", 32'(win_open), 32'd0);
        check("R10", "mask idle", 32'(sel_mask), 32'd0);

        // All eight sectors in reverse order (R4, R7)
        for (int i = 7; i >= 0; i--) begin
            pulse(1, 3'(i), 0, 0, 0, a);
            idle(2);
        end
        push_ev(a + W, 0, 8'hFF);
        idle(W);
        check("R7", "mask held after start", 32'(sel_mask), 32'hFF);
        pulse(0, 3'd0, 0, 0, 1, t);
        check("R9", "cleared after full erase", 32'(sel_mask), 32'd0);

        idle(5);
        check("R3", "pending expected events", 32'(exp_q.size()), 32'd0);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule